// File: doc/BRIEF.md
# Dual-Channel Memory Address Mapper

This block sits in front of a two-channel memory controller. It turns a flat physical byte address into a target channel and a byte address local to that channel. It picks the address organisation by itself from the installed capacity of each channel and from a zone-mode enable. If only one channel is populated, everything goes to that channel. If both channels hold the same amount, the two are interleaved line by line. If the amounts differ, the channels are either stacked one after the other or split into an interleaved low zone with a linear high zone above it.

Requests come in over a valid/ready handshake. Each one is translated in a single registered stage. The result is held until the consumer takes it. An address outside the installed memory gives an error result in place of a valid one. The capacity and mode inputs are captured only while the block is idle, so a reconfiguration never changes a translation that is already in flight. Capacities are assumed to be whole multiples of two cache lines (128 bytes by default).

Top module: `dcam_map_top`

## Requirements
- R1: With exactly one channel populated (nonzero capacity), every in-range address goes to that channel (chan 0 = channel A, 1 = channel B), the local address equals the request address, and the mode output is 0 (single).
- R2: With both capacities equal and nonzero, whatever the zone-mode enable, the mode output is 1 (interleaved) and the whole space is interleaved. Address bit 6 picks the channel (0 = A). The local address is the upper address bits above bit 6 shifted down by one place, joined with address bits 5:0.
- R3: With unequal nonzero capacities and zone mode off, the mode output is 2 (stacked). An address below channel B's capacity goes to B unchanged. A higher address goes to A with channel B's capacity subtracted.
- R4: With unequal nonzero capacities and zone mode on, the mode output is 3 (zoned). An address below twice the smaller capacity is interleaved as in R2. A higher address goes to the larger channel at local address (address minus the smaller capacity).
- R5: An address at or above the sum of both capacities gives rsp_err_o high and rsp_valid_o low for that result.
- R6: With no channel populated, every request gives an error result with mode output 0.
- R7: A request accepted on a clock edge (req_valid_i and req_ready_o both high) has its result presented right after that edge, with no extra cycle.
- R8: While a result is presented and rsp_ready_i is low, the result stays unchanged and req_ready_o is low.
- R9: Capacities and the zone enable are captured only on cycles where no result is pending and no request is presented. A request uses the configuration from the last such cycle.
- R10: rsp_valid_o and rsp_err_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_a_i | input | ADDR_W | Installed bytes in channel A |
| cap_b_i | input | ADDR_W | Installed bytes in channel B |
| flex_en_i | input | 1 | Enables the zoned organisation for unequal channels |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_addr_i | input | ADDR_W | Flat physical byte address |
| rsp_ready_i | input | 1 | Consumer takes the presented result |
| rsp_valid_o | output | 1 | Successful translation presented |
| rsp_err_o | output | 1 | Out-of-range result presented |
| rsp_chan_o | output | 1 | Target channel, 0 = A, 1 = B |
| rsp_addr_o | output | ADDR_W | Byte address within the target channel |
| rsp_mode_o | output | 2 | Resolved organisation: 0 single, 1 interleaved, 2 stacked, 3 zoned |

## Verification
The mapper is tried with no channel, each channel alone, equal channels with and without the zone enable, stacked channels, and zoned channels with the larger side on A and then on B. Addresses are picked just below and at each boundary: the line-bit flip, the top of channel B, the top of the interleaved zone and the total capacity. This separates a wrong boundary compare from a wrong local-address formula. A run of consecutive lines with no gaps checks that the channel alternates at full rate. A stalled consumer while the capacities change checks that results are held and that the new configuration is taken only after the block goes idle.

// File: rtl/dcam_pkg.sv
// Shared types for the dual-channel address mapper.
package dcam_pkg;

    // Resolved address organisation; the encoding is visible at the top port.
    typedef enum logic [1:0] {
        MAP_SINGLE = 2'd0,
        MAP_INTLV  = 2'd1,
        MAP_ASYM   = 2'd2,
        MAP_FLEX   = 2'd3
    } map_mode_e;

    // Channel select encoding.
    localparam logic CHAN_A = 1'b0;
    localparam logic CHAN_B = 1'b1;

endpackage

// File: rtl/dcam_cfg.sv
// Configuration capture and mode resolution.
// Registers the channel capacities and zone enable when load is high, and
// derives the organisation, total size, smaller capacity and zone top from
// the registered values. Assumes capacities are multiples of two lines.
module dcam_cfg
    import dcam_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] cap_a_i,
    input  logic [ADDR_W-1:0] cap_b_i,
    input  logic              flex_en_i,
    output map_mode_e         mode_o,
    output logic [ADDR_W-1:0] cap_b_o,
    output logic [ADDR_W-1:0] cap_min_o,
    output logic [ADDR_W:0]   total_o,
    output logic [ADDR_W:0]   zone_top_o,
    output logic              big_is_b_o,
    output logic              only_b_o
);

    localparam int TOT_W = ADDR_W + 1;

    logic [ADDR_W-1:0] cap_a_q;
    logic [ADDR_W-1:0] cap_b_q;
    logic              flex_q;

    // Capture the configuration only when the owner says the block is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a_q <= '0;
            cap_b_q <= '0;
            flex_q  <= 1'b0;
        end else if (load) begin
            cap_a_q <= cap_a_i;
            cap_b_q <= cap_b_i;
            flex_q  <= flex_en_i;
        end
    end

    logic a_pop;
    logic b_pop;

    // Derive the organisation and the boundaries from the captured sizes.
    always_comb begin
        a_pop      = (cap_a_q != '0);
        b_pop      = (cap_b_q != '0);
        cap_min_o  = (cap_a_q < cap_b_q) ? cap_a_q : cap_b_q;
        total_o    = TOT_W'(cap_a_q) + TOT_W'(cap_b_q);
        zone_top_o = {cap_min_o, 1'b0};
        big_is_b_o = (cap_b_q > cap_a_q);
        only_b_o   = !a_pop;
        cap_b_o    = cap_b_q;
        if (!(a_pop && b_pop))       mode_o = MAP_SINGLE;
        else if (cap_a_q == cap_b_q) mode_o = MAP_INTLV;
        else if (flex_q)             mode_o = MAP_FLEX;
        else                         mode_o = MAP_ASYM;
    end

endmodule

// File: rtl/dcam_xlate.sv
// Combinational address translation.
// Given the resolved organisation and boundaries, picks the channel and the
// channel-local byte address and flags addresses beyond the installed total.
// Assumes LINE_W + 1 < ADDR_W.
module dcam_xlate
    import dcam_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  map_mode_e         mode_i,
    input  logic [ADDR_W-1:0] cap_b_i,
    input  logic [ADDR_W-1:0] cap_min_i,
    input  logic [ADDR_W:0]   total_i,
    input  logic [ADDR_W:0]   zone_top_i,
    input  logic              big_is_b_i,
    input  logic              only_b_i,
    output logic              err_o,
    output logic              chan_o,
    output logic [ADDR_W-1:0] local_o
);

    localparam int TOT_W = ADDR_W + 1;

    logic [ADDR_W-1:0] il_local;
    logic              il_chan;
    logic              in_zone;

    // Interleaved split: the line bit picks the channel and is squeezed out.
    always_comb begin
        il_chan  = addr_i[LINE_W];
        il_local = {1'b0, addr_i[ADDR_W-1:LINE_W+1], addr_i[LINE_W-1:0]};
        in_zone  = (TOT_W'(addr_i) < zone_top_i);
    end

    // Per-organisation channel and local address selection.
    always_comb begin
        err_o   = (TOT_W'(addr_i) >= total_i);
        chan_o  = CHAN_A;
        local_o = addr_i;
        unique case (mode_i)
            MAP_SINGLE: begin
                chan_o  = only_b_i ? CHAN_B : CHAN_A;
                local_o = addr_i;
            end
            MAP_INTLV: begin
                chan_o  = il_chan;
                local_o = il_local;
            end
            MAP_ASYM: begin
                if (addr_i < cap_b_i) begin
                    chan_o  = CHAN_B;
                    local_o = addr_i;
                end else begin
                    chan_o  = CHAN_A;
                    local_o = addr_i - cap_b_i;
                end
            end
            MAP_FLEX: begin
                if (in_zone) begin
                    chan_o  = il_chan;
                    local_o = il_local;
                end else begin
                    chan_o  = big_is_b_i ? CHAN_B : CHAN_A;
                    local_o = addr_i - cap_min_i;
                end
            end
            default: begin
                chan_o  = CHAN_A;
                local_o = addr_i;
            end
        endcase
    end

endmodule

// File: rtl/dcam_rsp_reg.sv
// One-entry result register with a valid/ready handshake on both sides.
// Takes a new result when empty or when the held one is drained on the same
// edge; holds its contents while the consumer stalls.
module dcam_rsp_reg
    import dcam_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic              in_err_i,
    input  logic              in_chan_i,
    input  logic [ADDR_W-1:0] in_addr_i,
    input  map_mode_e         in_mode_i,
    input  logic              out_ready_i,
    output logic              full_o,
    output logic              err_o,
    output logic              chan_o,
    output logic [ADDR_W-1:0] addr_o,
    output map_mode_e         mode_o
);

    logic full_q;

    // Room for a new result when empty or being drained this cycle.
    assign in_ready_o = !full_q || out_ready_i;
    assign full_o     = full_q;

    // Load, hold or drain the single result slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            err_o  <= 1'b0;
            chan_o <= CHAN_A;
            addr_o <= '0;
            mode_o <= MAP_SINGLE;
        end else if (in_valid_i && in_ready_o) begin
            full_q <= 1'b1;
            err_o  <= in_err_i;
            chan_o <= in_chan_i;
            addr_o <= in_addr_i;
            mode_o <= in_mode_i;
        end else if (out_ready_i) begin
            full_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dcam_map_top.sv
// Dual-channel address mapper top.
// Captures configuration while idle, translates each accepted request in one
// registered stage and presents either a valid result or an error result.
module dcam_map_top
    import dcam_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cap_a_i,
    input  logic [ADDR_W-1:0] cap_b_i,
    input  logic              flex_en_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              rsp_ready_i,
    output logic              rsp_valid_o,
    output logic              rsp_err_o,
    output logic              rsp_chan_o,
    output logic [ADDR_W-1:0] rsp_addr_o,
    output logic [1:0]        rsp_mode_o
);

    map_mode_e         mode;
    logic [ADDR_W-1:0] cap_b;
    logic [ADDR_W-1:0] cap_min;
    logic [ADDR_W:0]   total;
    logic [ADDR_W:0]   zone_top;
    logic              big_is_b;
    logic              only_b;
    logic              full;
    logic              cfg_load;
    logic              x_err;
    logic              x_chan;
    logic [ADDR_W-1:0] x_local;
    logic              h_err;
    map_mode_e         h_mode;

    // Idle means nothing held and nothing offered.
    assign cfg_load = !full && !req_valid_i;

    dcam_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .cap_a_i    (cap_a_i),
        .cap_b_i    (cap_b_i),
        .flex_en_i  (flex_en_i),
        .mode_o     (mode),
        .cap_b_o    (cap_b),
        .cap_min_o  (cap_min),
        .total_o    (total),
        .zone_top_o (zone_top),
        .big_is_b_o (big_is_b),
        .only_b_o   (only_b)
    );

    dcam_xlate #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_xlate (
        .addr_i     (req_addr_i),
        .mode_i     (mode),
        .cap_b_i    (cap_b),
        .cap_min_i  (cap_min),
        .total_i    (total),
        .zone_top_i (zone_top),
        .big_is_b_i (big_is_b),
        .only_b_i   (only_b),
        .err_o      (x_err),
        .chan_o     (x_chan),
        .local_o    (x_local)
    );

    dcam_rsp_reg #(.ADDR_W(ADDR_W)) u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (req_valid_i),
        .in_ready_o  (req_ready_o),
        .in_err_i    (x_err),
        .in_chan_i   (x_chan),
        .in_addr_i   (x_local),
        .in_mode_i   (mode),
        .out_ready_i (rsp_ready_i),
        .full_o      (full),
        .err_o       (h_err),
        .chan_o      (rsp_chan_o),
        .addr_o      (rsp_addr_o),
        .mode_o      (h_mode)
    );

    // Split the held result into the valid and error flags.
    assign rsp_valid_o = full && !h_err;
    assign rsp_err_o   = full && h_err;
    assign rsp_mode_o  = h_mode;

endmodule

// File: rtl/dcam_chk.sv
// Protocol and mapping checks for the address mapper, bound to the top.
module dcam_chk
    import dcam_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              rsp_ready_i,
    input logic              rsp_valid_o,
    input logic              rsp_err_o,
    input logic              rsp_chan_o,
    input logic [ADDR_W-1:0] rsp_addr_o,
    input logic [1:0]        rsp_mode_o
);

    logic [ADDR_W-1:0] acc_q;

    // Remember the most recently accepted request address.
    always_ff @(posedge clk) begin
        if (!rst_n)                         acc_q <= '0;
        else if (req_valid_i && req_ready_o) acc_q <= req_addr_i;
    end

    AST_NO_DUAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid_o && rsp_err_o)); // R10

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> (rsp_valid_o || rsp_err_o)); // R7

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_ready_i) |=>
            (rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_chan_o) && $stable(rsp_mode_o))); // R8

    AST_BLOCK_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsp_valid_o || rsp_err_o) && !rsp_ready_i) |-> !req_ready_o); // R8

    AST_SINGLE_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_mode_o == MAP_SINGLE) |-> (rsp_addr_o == acc_q)); // R1

    AST_INTLV_LINE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_mode_o == MAP_INTLV) |-> (rsp_chan_o == acc_q[LINE_W])); // R2

endmodule

bind dcam_map_top dcam_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_dcam_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .rsp_ready_i (rsp_ready_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_chan_o  (rsp_chan_o),
    .rsp_addr_o  (rsp_addr_o),
    .rsp_mode_o  (rsp_mode_o)
);

// File: tb/dcam_map_top_bench.sv
// Scoreboard bench for the dual-channel address mapper.
module dcam_map_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;

    typedef struct packed {
        logic          err;
        logic          chan;
        logic [1:0]    mode;
        logic [AW-1:0] addr;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cap_a = '0;
    logic [AW-1:0] cap_b = '0;
    logic          flex_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_ready = 1'b1;
    logic          rsp_valid;
    logic          rsp_err;
    logic          rsp_chan;
    logic [AW-1:0] rsp_addr;
    logic [1:0]    rsp_mode;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    exp_t  exp_q[$];
    string tag_q[$];

    // Configuration the bench believes the design has captured.
    logic [AW-1:0] cur_a = '0;
    logic [AW-1:0] cur_b = '0;
    logic          cur_f = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcam_map_top #(.ADDR_W(AW), .LINE_W(6)) u_dcam_map_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_a_i     (cap_a),
        .cap_b_i     (cap_b),
        .flex_en_i   (flex_en),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_addr_i  (req_addr),
        .rsp_ready_i (rsp_ready),
        .rsp_valid_o (rsp_valid),
        .rsp_err_o   (rsp_err),
        .rsp_chan_o  (rsp_chan),
        .rsp_addr_o  (rsp_addr),
        .rsp_mode_o  (rsp_mode)
    );

    // Reference mapping written from the requirements.
    function automatic exp_t model(input logic [AW-1:0] a, input logic [AW-1:0] ca,
                                   input logic [AW-1:0] cb, input logic f);
        exp_t e;
        logic [AW:0]   tot;
        logic [AW-1:0] mn;
        e   = '0;
        tot = {1'b0, ca} + {1'b0, cb};
        mn  = (ca < cb) ? ca : cb;
        if (ca == 0 || cb == 0) e.mode = 2'd0;
        else if (ca == cb)      e.mode = 2'd1;
        else if (f)             e.mode = 2'd3;
        else                    e.mode = 2'd2;
        e.err = ({1'b0, a} >= tot);
        case (e.mode)
            2'd0: begin e.chan = (ca == 0); e.addr = a; end
            2'd1: begin e.chan = a[6]; e.addr = ((a >> 7) << 6) | (a & 32'h3F); end
            2'd2: begin
                if (a < cb) begin e.chan = 1'b1; e.addr = a; end
                else        begin e.chan = 1'b0; e.addr = a - cb; end
            end
            default: begin
                if ({1'b0, a} < {mn, 1'b0}) begin
                    e.chan = a[6]; e.addr = ((a >> 7) << 6) | (a & 32'h3F);
                end else begin
                    e.chan = (cb > ca); e.addr = a - mn;
                end
            end
        endcase
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // Drive new configuration and let the design sit idle long enough to take it.
    task automatic set_cfg(input logic [AW-1:0] a, input logic [AW-1:0] b, input logic f);
        cap_a = a; cap_b = b; flex_en = f;
        repeat (3) @(negedge clk);
        cur_a = a; cur_b = b; cur_f = f;
    endtask

    // Present one request (called at a falling edge) and log its expectation.
    task automatic send(input logic [AW-1:0] a, input string tag);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(model(a, cur_a, cur_b, cur_f));
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare every result the consumer takes against the queue.
    always @(negedge clk) begin
        #1;
        if (rst_n && (rsp_valid || rsp_err) && rsp_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected result", {31'd0, rsp_valid, rsp_addr}, 64'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e.err)
                    chk(rsp_err && !rsp_valid && rsp_mode == e.mode, t,
                        {rsp_err, rsp_valid, rsp_mode}, {1'b1, 1'b0, e.mode});
                else
                    chk(rsp_valid && !rsp_err && rsp_chan == e.chan &&
                        rsp_addr == e.addr && rsp_mode == e.mode, t,
                        {rsp_valid, rsp_err, rsp_mode, rsp_chan, rsp_addr},
                        {1'b1, 1'b0, e.mode, e.chan, e.addr});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!rsp_valid && !rsp_err && req_ready, "R7 reset state idle",
            {rsp_valid, rsp_err, req_ready}, 3'b001);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: no channel populated.
        set_cfg(32'h0, 32'h0, 1'b0);
        send(32'h0, "R6 empty addr 0");
        send(32'h40, "R6 empty addr 0x40");

        // R1 / R5: only channel A, then only channel B.
        set_cfg(32'h1000, 32'h0, 1'b0);
        send(32'h0,   "R1 single A low");
        send(32'h40,  "R1 single A next line");
        send(32'hFFF, "R1 single A top byte");
        send(32'h1000, "R5 single A at total");
        set_cfg(32'h0, 32'h800, 1'b1);
        send(32'h7C0, "R1 single B");
        send(32'h800, "R5 single B at total");

        // R2: equal channels, consecutive lines back to back.
        set_cfg(32'h1000, 32'h1000, 1'b0);
        for (int i = 0; i < 6; i++) send(32'(i * 64 + 5), "R2 consecutive lines");
        send(32'h1FFF, "R2 top byte");
        send(32'h2000, "R5 interleaved at total");
        set_cfg(32'h1000, 32'h1000, 1'b1);
        send(32'hC5, "R2 equal with zone enable");

        // R3: stacked channels.
        set_cfg(32'h1000, 32'h800, 1'b0);
        send(32'h7FF,  "R3 last byte of B");
        send(32'h800,  "R3 first byte of A");
        send(32'h17FF, "R3 last byte of A");
        send(32'h1800, "R5 stacked at total");

        // R4: zoned, larger channel A then larger channel B.
        set_cfg(32'h1000, 32'h800, 1'b1);
        send(32'h40,   "R4 zone line B");
        send(32'hFC0,  "R4 zone last line");
        send(32'h1000, "R4 linear start on A");
        send(32'h17FF, "R4 linear top on A");
        send(32'h1800, "R5 zoned at total");
        set_cfg(32'h400, 32'hC00, 1'b1);
        send(32'h7FF, "R4 zone top byte");
        send(32'h800, "R4 linear start on B");

        // R8 / R9: stall the consumer and change configuration meanwhile.
        set_cfg(32'h1000, 32'h1000, 1'b0);
        rsp_ready = 1'b0;
        send(32'h40, "R8 held result");
        cap_a = 32'h1000; cap_b = 32'h0; flex_en = 1'b0;
        req_valid = 1'b1; req_addr = 32'h40;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(rsp_valid && rsp_chan && rsp_addr == 32'h0 && !req_ready,
                "R8 stall holds result and blocks request",
                {rsp_valid, rsp_chan, req_ready, rsp_addr}, {3'b110, 32'h0});
            @(negedge clk);
        end
        rsp_ready = 1'b1;
        exp_q.push_back(model(32'h40, 32'h1000, 32'h1000, 1'b0));
        tag_q.push_back("R9 request uses pre-stall configuration");
        #1;
        chk(req_ready, "R8 ready returns with consumer", {63'd0, req_ready}, 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        cur_a = 32'h1000; cur_b = 32'h0; cur_f = 1'b0;
        send(32'h40, "R9 new configuration after idle");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all results returned", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule